// File: doc/BRIEF.md
# Programmable Fill-Threshold Flag Generator

This block watches the write and read pointers of a dual-clock FIFO and turns their difference into three active-low status flags. The first reports that only a few words remain. The second reports that more than half the depth is used. The third reports that only a few free slots remain. The storage array and the data path sit outside the block; the block sees only the two binary pointers. Each pointer is one bit wider than the address, so that a full FIFO and an empty FIFO give different pointer values.

The "few words" and "few free slots" thresholds are two offset registers, clocked on the write clock. A master reset loads both offsets with one of two built-in default values, chosen by a select pin. After reset, software-side logic can overwrite the offsets in one of two ways. A serial stream shifts in one bit per write-clock edge. A parallel bus writes one whole word per load strobe. A readback strobe returns the offsets one at a time. A partial reset restarts the flag logic and the load and readback sequences, and it leaves the offsets as they are.

Each flag is timed in a different way. The low-fill flag lives in the read-clock domain and is registered. The high-fill flag lives in the write-clock domain. The half-full flag is decoded directly from both pointers, with no clock. The offsets are treated as quasi-static: they are changed only while the FIFO is idle.

Top module: `pflag_ctrl`

## Requirements
- R1: With master reset applied and both pointers at zero, the flags settle to: low-fill flag `ae_n`=0, half flag `hf_n`=1, high-fill flag `af_n`=1.
- R2: A master reset loads both offsets with `DEF_LO` when `dflt_sel`=0, and with `DEF_HI` when `dflt_sel`=1. The value of `dflt_sel` is the one seen at the write-clock edge during reset.
- R3: Serial loading happens while `ser_mode`=1 and `load`=1. On each write-clock edge, `ser_in` is stored as the next bit, least significant bit first. The first AW bits fill the empty offset, the next AW bits fill the full offset, and then the sequence wraps around.
- R4: Parallel loading happens while `ser_mode`=0. The first `load` edge writes `par_in` into the empty offset, the second `load` edge writes the full offset, and the pattern then alternates.
- R5: A write-clock edge with `rdbk`=1 places one offset on `off_out`, and the value is visible after that same edge. The first readback gives the empty offset, the next gives the full offset, and the pattern then alternates.
- R6: A partial reset (`prst_n`=0) leaves both offsets unchanged. It restarts the serial, parallel and readback sequences, so the next readback gives the empty offset again.
- R7: The fill level is `wr_ptr - rd_ptr`, taken modulo 2^(AW+1). `ae_n` is 0 exactly when the fill level is at or below the empty offset.
- R8: A change of `rd_ptr` shows on `ae_n` after the second read-clock edge that follows the change, and not after the first edge.
- R9: `af_n` is 0 exactly when 2^AW minus the fill level is at or below the full offset. A change of `rd_ptr` shows on `af_n` after the second write-clock edge that follows it, and not after the first.
- R10: `hf_n` is 0 exactly when the fill level exceeds 2^(AW-1). It follows pointer changes with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low; offsets kept |
| dflt_sel | input | 1 | Chooses DEF_LO (0) or DEF_HI (1) at master reset |
| ser_mode | input | 1 | 1 = serial offset loading, 0 = parallel |
| load | input | 1 | Offset load strobe (write clock) |
| ser_in | input | 1 | Serial offset bit |
| par_in | input | AW | Parallel offset word |
| rdbk | input | 1 | Offset readback strobe (write clock) |
| wr_ptr | input | AW+1 | Binary write pointer, write-clock domain |
| rd_ptr | input | AW+1 | Binary read pointer, read-clock domain |
| ae_n | output | 1 | Low-fill flag, active low |
| hf_n | output | 1 | Half-full flag, active low |
| af_n | output | 1 | High-fill flag, active low |
| off_out | output | AW | Offset readback value |

## Verification
Each flag is sampled one time unit after the clock edge at which its result is due. A change of `rd_ptr` reaches `ae_n` after the second read-clock edge and `af_n` after the second write-clock edge, so the bench checks that the old value still holds after the first edge and the new value after the second. `hf_n` is checked half a time unit after a pointer change, before any clock edge can occur. A readback value is checked just after the write-clock edge that sampled `rdbk`. For the table of pointer pairs, the bench waits several read-clock periods after each new pair so that both synchronizers have settled.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  typedef enum logic {SLOT_EMPTY = 1'b0, SLOT_FULL = 1'b1} slot_e;

  function automatic slot_e next_slot(input slot_e s);
    return (s == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
  endfunction
endpackage

// File: rtl/pflag_offsets.sv
module pflag_offsets
  import pflag_pkg::*;
#(
  parameter int AW     = 10,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 127
) (
  input  logic          wr_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          dflt_sel,
  input  logic          ser_mode,
  input  logic          load,
  input  logic          ser_in,
  input  logic [AW-1:0] par_in,
  input  logic          rdbk,
  output logic [AW-1:0] empty_off,
  output logic [AW-1:0] full_off,
  output logic [AW-1:0] off_out
);
  localparam int BW = 2 * AW;
  localparam int CW = $clog2(BW);

  // {full, empty}: serial bit k lands at position k
  logic [BW-1:0] offs_q;
  logic [CW-1:0] bit_idx;
  slot_e         par_slot;
  slot_e         rb_slot;

  assign empty_off = offs_q[AW-1:0];
  assign full_off  = offs_q[BW-1:AW];

  always_ff @(posedge wr_clk) begin
    if (!mrst_n) begin
      offs_q   <= dflt_sel ? {2{AW'(DEF_HI)}} : {2{AW'(DEF_LO)}};
      bit_idx  <= '0;
      par_slot <= SLOT_EMPTY;
      rb_slot  <= SLOT_EMPTY;
      off_out  <= '0;
    end else if (!prst_n) begin
      bit_idx  <= '0;
      par_slot <= SLOT_EMPTY;
      rb_slot  <= SLOT_EMPTY;
    end else begin
      if (load) begin
        if (ser_mode) begin
          offs_q[bit_idx] <= ser_in;
          bit_idx <= (bit_idx == CW'(BW - 1)) ? '0 : bit_idx + 1'b1;
        end else begin
          if (par_slot == SLOT_EMPTY) offs_q[AW-1:0]  <= par_in;
          else                        offs_q[BW-1:AW] <= par_in;
          par_slot <= next_slot(par_slot);
        end
      end
      if (rdbk) begin
        off_out <= (rb_slot == SLOT_EMPTY) ? offs_q[AW-1:0] : offs_q[BW-1:AW];
        rb_slot <= next_slot(rb_slot);
      end
    end
  end
endmodule

// File: rtl/pflag_ptr_sync.sv
module pflag_ptr_sync #(
  parameter int PW = 11
) (
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_bin,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0] src_gray;
  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;

  assign src_gray = src_bin ^ (src_bin >> 1);

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    dst_bin[PW-1] = sync_q[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      dst_bin[i] = dst_bin[i+1] ^ sync_q[i];
    end
  end
endmodule

// File: rtl/pflag_ctrl.sv
module pflag_ctrl #(
  parameter int AW     = 10,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 127
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          dflt_sel,
  input  logic          ser_mode,
  input  logic          load,
  input  logic          ser_in,
  input  logic [AW-1:0] par_in,
  input  logic          rdbk,
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr,
  output logic          ae_n,
  output logic          hf_n,
  output logic          af_n,
  output logic [AW-1:0] off_out
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic          rst_all_n;
  logic [AW-1:0] empty_off;
  logic [AW-1:0] full_off;
  logic [PW-1:0] rd_ptr_w;
  logic [PW-1:0] wr_ptr_r;
  logic [PW-1:0] rd_ptr_q;
  logic [PW-1:0] fill_w;
  logic [PW-1:0] free_w;
  logic [PW-1:0] fill_r;
  logic [PW-1:0] fill_a;
  logic          ae_q;

  assign rst_all_n = mrst_n & prst_n;

  pflag_offsets #(.AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_offs (
    .wr_clk, .mrst_n, .prst_n, .dflt_sel, .ser_mode, .load, .ser_in,
    .par_in, .rdbk, .empty_off, .full_off, .off_out
  );

  // read pointer into the write domain, write pointer into the read domain
  pflag_ptr_sync #(.PW(PW)) u_rd2wr (
    .dst_clk(wr_clk), .rst_n(rst_all_n), .src_bin(rd_ptr), .dst_bin(rd_ptr_w)
  );
  pflag_ptr_sync #(.PW(PW)) u_wr2rd (
    .dst_clk(rd_clk), .rst_n(rst_all_n), .src_bin(wr_ptr), .dst_bin(wr_ptr_r)
  );

  // write domain: decode from write-clock flops only
  assign fill_w = wr_ptr - rd_ptr_w;
  assign free_w = PW'(DEPTH) - fill_w;
  assign af_n   = !(free_w <= {1'b0, full_off});

  // read domain: pointer stage then registered flag
  assign fill_r = wr_ptr_r - rd_ptr_q;

  always_ff @(posedge rd_clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      rd_ptr_q <= '0;
      ae_q     <= 1'b0;
    end else begin
      rd_ptr_q <= rd_ptr;
      ae_q     <= !(fill_r <= {1'b0, empty_off});
    end
  end
  assign ae_n = ae_q;

  // unclocked half-level decode
  assign fill_a = wr_ptr - rd_ptr;
  assign hf_n   = !(fill_a > PW'(HALF));
endmodule

// File: rtl/pflag_ctrl_chk.sv
module pflag_ctrl_chk #(
  parameter int AW     = 10,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 127
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          dflt_sel,
  input logic [AW:0]   wr_ptr,
  input logic [AW:0]   rd_ptr,
  input logic          ae_n,
  input logic          af_n,
  input logic [AW-1:0] empty_off,
  input logic [AW-1:0] full_off
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [1:0]    wcnt;
  logic [2:0]    rcnt;
  logic [PW-1:0] fill_ref;
  logic [PW-1:0] free_ref;
  logic          rst_all_n;

  assign rst_all_n = mrst_n & prst_n;
  assign fill_ref  = wr_ptr - rd_ptr;
  assign free_ref  = PW'(DEPTH) - fill_ref;

  always_ff @(posedge wr_clk) begin
    if (!rst_all_n)     wcnt <= '0;
    else if (wcnt != 3) wcnt <= wcnt + 1'b1;
  end
  always_ff @(posedge rd_clk) begin
    if (!rst_all_n)     rcnt <= '0;
    else if (rcnt != 4) rcnt <= rcnt + 1'b1;
  end

  // R2: defaults present once master reset lifts
  a_r2_mrst_default: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    $rose(mrst_n) |->
      (empty_off == ($past(dflt_sel) ? AW'(DEF_HI) : AW'(DEF_LO))) &&
      (full_off  == ($past(dflt_sel) ? AW'(DEF_HI) : AW'(DEF_LO))));

  // R6: offsets untouched across partial reset
  a_r6_prst_keeps: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    !prst_n |=> $stable(empty_off) && $stable(full_off));

  // R9: settled high-fill flag matches free space
  a_r9_af_settled: assert property (@(posedge wr_clk) disable iff (!rst_all_n)
    (wcnt == 3 && $stable(rd_ptr) && $past($stable(rd_ptr))) |->
      (af_n == !(free_ref <= {1'b0, full_off})));

  // R7 / R8: settled low-fill flag matches fill level
  a_r7_ae_settled: assert property (@(posedge rd_clk) disable iff (!rst_all_n)
    (rcnt == 4 && $stable(rd_ptr) && $past($stable(rd_ptr)) &&
     $stable(wr_ptr) && $past($stable(wr_ptr)) && $past($stable(wr_ptr), 2) &&
     $stable(empty_off) && $past($stable(empty_off))) |->
      (ae_n == !(fill_ref <= {1'b0, empty_off})));

  // R8: no read-pointer effect on the flag after just one edge
  a_r8_ae_hold: assert property (@(posedge rd_clk) disable iff (!rst_all_n)
    (rcnt == 4 && $stable(wr_ptr) && $past($stable(wr_ptr)) &&
     $stable(empty_off) && !$stable(rd_ptr)) |=> $stable(ae_n));
endmodule

bind pflag_ctrl pflag_ctrl_chk #(.AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
  .dflt_sel(dflt_sel), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ae_n(ae_n),
  .af_n(af_n), .empty_off(empty_off), .full_off(full_off)
);

// File: tb/pflag_ctrl_tb_top.sv
`timescale 1ns/100ps
module pflag_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int AW = 4;
  localparam int LO = 2;
  localparam int HI = 5;
  localparam int NV = 10;
  // wr, rd, expected ae_n, hf_n, af_n  (empty offset 3, full offset 4)
  localparam int VEC [NV][5] = '{
    '{0, 0, 0, 1, 1}, '{3, 0, 0, 1, 1}, '{4, 0, 1, 1, 1}, '{9, 0, 1, 0, 1},
    '{8, 0, 1, 1, 1}, '{12, 0, 1, 0, 0}, '{11, 0, 1, 0, 1}, '{16, 0, 1, 0, 0},
    '{2, 18, 1, 0, 0}, '{20, 17, 0, 1, 1}};

  logic wr_clk = 0, rd_clk = 0;
  logic mrst_n = 0, prst_n = 1, dflt_sel = 0, ser_mode = 0, load = 0, ser_in = 0, rdbk = 0;
  logic [AW-1:0] par_in = '0;
  logic [AW:0] wp = '0, rp = '0;
  logic ae_n, hf_n, af_n;
  logic [AW-1:0] off_out;
  int nchk = 0, nerr = 0, v;
  bit done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  pflag_ctrl #(.AW(AW), .DEF_LO(LO), .DEF_HI(HI)) dut_i (
    .wr_clk, .rd_clk, .mrst_n, .prst_n, .dflt_sel, .ser_mode, .load, .ser_in,
    .par_in, .rdbk, .wr_ptr(wp), .rd_ptr(rp), .ae_n, .hf_n, .af_n, .off_out);

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask
  task automatic wtick(); @(posedge wr_clk); #1; endtask
  task automatic rtick(); @(posedge rd_clk); #1; endtask
  task automatic read_off(output int r);
    wtick(); rdbk = 1; wtick(); rdbk = 0; r = int'(off_out);
  endtask
  task automatic par_load(input int x);
    wtick(); ser_mode = 0; par_in = AW'(x); load = 1; wtick(); load = 0;
  endtask
  task automatic ser_load(input int e, input int f);
    wtick(); ser_mode = 1; load = 1;
    for (int i = 0; i < 2*AW; i++) begin
      ser_in = (i < AW) ? e[i] : f[i-AW];
      wtick();
    end
    load = 0; ser_mode = 0;
  endtask
  task automatic master_reset(input logic sel);
    mrst_n = 0; dflt_sel = sel; repeat (3) rtick(); wtick(); mrst_n = 1; wtick();
  endtask
  task automatic settle(); repeat (5) rtick(); endtask

  initial begin
    master_reset(1'b0);
    settle();
    chk("R1 ae_n", ae_n, 0); chk("R1 hf_n", hf_n, 1); chk("R1 af_n", af_n, 1);
    read_off(v); chk("R2 sel0 empty", v, LO);
    read_off(v); chk("R2 sel0 full", v, LO);
    master_reset(1'b1);
    read_off(v); chk("R2 sel1 empty", v, HI);
    read_off(v); chk("R2 sel1 full", v, HI);
    par_load(3); par_load(4);
    read_off(v); chk("R4 R5 empty first", v, 3);
    read_off(v); chk("R4 R5 full second", v, 4);
    read_off(v); chk("R5 wrap to empty", v, 3);
    ser_load(9, 6);
    read_off(v); chk("R3 serial full", v, 6);
    read_off(v); chk("R3 serial empty", v, 9);
    prst_n = 0; repeat (3) rtick(); wtick(); prst_n = 1; wtick();
    read_off(v); chk("R6 kept empty, sequence restarted", v, 9);
    read_off(v); chk("R6 kept full", v, 6);
    par_load(3); par_load(4);
    for (int i = 0; i < NV; i++) begin
      wtick(); wp = (AW+1)'(VEC[i][0]); rp = (AW+1)'(VEC[i][1]);
      settle();
      chk($sformatf("R7 ae_n vec%0d", i), ae_n, VEC[i][2]);
      chk($sformatf("R10 hf_n vec%0d", i), hf_n, VEC[i][3]);
      chk($sformatf("R9 af_n vec%0d", i), af_n, VEC[i][4]);
    end
    // R8: read-side change reaches ae_n on second read edge
    wp = 4; rp = 0; settle();
    chk("R8 start", ae_n, 1);
    rtick(); rp = 1;
    rtick(); chk("R8 after first edge", ae_n, 1);
    rtick(); chk("R8 after second edge", ae_n, 0);
    // R9: read-side change reaches af_n on second write edge
    wp = 12; rp = 1; settle();
    chk("R9 start", af_n, 1);
    wtick(); rp = 0;
    wtick(); chk("R9 after first edge", af_n, 1);
    wtick(); chk("R9 after second edge", af_n, 0);
    // R10: half flag with no clock edge
    wp = 4; rp = 0; settle();
    chk("R10 start", hf_n, 1);
    wtick(); wp = 9; #0.5;
    chk("R10 immediate", hf_n, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule